// File: doc/BRIEF.md
# Prefix-Operand Accumulator Core

This block is a small accumulator processor with a 32-bit datapath. Its program is a stream of single-byte instructions: the upper nibble selects the operation and the lower nibble carries four bits of operand. Operands wider than four bits are built by placing one or more prefix bytes in front of the instruction that uses them. Each prefix folds its nibble into a hidden operand register and shifts it up. The architectural state is a program counter, an accumulator A, a second register B and that operand register.

One synchronous memory port, with word addressing and a read latency of one cycle, carries both instruction fetches and data accesses. An instruction takes a fetch cycle and an execute cycle. A load takes one more cycle to write the returned word into its register. A system call stops the core and presents A and B on a trap port until the surrounding system acknowledges it. An undefined encoding stops the core for good, until the next reset.

Top module: `accum_core`

## Requirements
- R1: Each instruction begins with a cycle that reads memory word PC>>2. The instruction is byte PC[1:0] of that word, with byte 0 in bits 7:0 (little-endian). Bits 7:4 are the opcode and bits 3:0 are the nibble. PC advances by one byte per instruction.
- R2: The effective operand is the operand register OR the zero-extended nibble. Opcode 0xE sets the operand register to (operand << 4). Opcode 0xF sets it to (~operand) << 4. Every other opcode clears it.
- R3: Opcode 0x3 loads A with the operand. Opcode 0x4 loads B with the operand. Opcode 0x5 loads A with (PC+1) + operand.
- R4: Opcode 0x0 loads A, and opcode 0x1 loads B, from the memory word at the operand. Opcode 0x2 writes A to the memory word at the operand.
- R5: Opcodes 0x6, 0x7 and 0x8 work like 0x0, 0x1 and 0x2, but address the word at B + operand.
- R6: Opcode 0x9 sets PC to (PC+1) + operand. Opcode 0xA does the same only when A is zero. Opcode 0xB does the same only when A bit 31 is set. A conditional jump that is not taken continues at PC+1.
- R7: Opcode 0xD chooses its function from the operand. Function 0 sets PC to B. Function 1 sets A to A+B. Function 2 sets A to A−B. Both arithmetic results wrap modulo 2^32.
- R8: Opcode 0xD with function 3 raises trap_o from the cycle after its execute cycle. While the trap is held, trap_a_o and trap_b_o show A and B, and the port stays idle. The trap ends at the clock edge where trap_ack_i is high, and execution then resumes at the next byte.
- R9: Opcode 0xC, and opcode 0xD with an operand above 3 (prefixed operands included), raise halt_o from the cycle after the execute cycle. From then on there is no memory access and no trap until reset.
- R10: A synchronous active-high reset clears PC, A, B and the operand register. During reset the port presents a fetch of word 0, and trap_o, halt_o and mem_wr_o are low.
- R11: A read and a write are never presented in the same cycle. A load takes three cycles: fetch, address, and write-back with the port idle. Every other non-trapping instruction takes two cycles, and a store drives its write in its second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | 32 | Word address for a fetch, load or store |
| mem_rd_o | output | 1 | Read request; data returns on mem_rdata_i one cycle later |
| mem_wr_o | output | 1 | Write request for mem_wdata_o at mem_addr_o |
| mem_wdata_o | output | 32 | Store data (A) |
| mem_rdata_i | input | 32 | Read data, registered by the memory |
| trap_o | output | 1 | System call pending |
| trap_a_o | output | 32 | A while trap_o is high, zero otherwise |
| trap_b_o | output | 32 | B while trap_o is high, zero otherwise |
| trap_ack_i | input | 1 | Ends a pending system call |
| halt_o | output | 1 | Core stopped on an undefined encoding |

## Verification
The fetch read of an instruction appears in the first cycle after the previous instruction finishes. Its store or data read appears one cycle later, and a loaded value can only affect the third cycle or later. A trap starts the cycle after the execute cycle and ends one cycle after the acknowledge is sampled. The bench's reference model expands each executed instruction into exactly that sequence of per-cycle port expectations. The bench compares one expectation against the port at every falling edge, so an early, late or missing access is caught in the cycle where it differs. The bench raises the trap acknowledge on the third trap cycle, so every system call has a fixed, known length.

// File: rtl/accum_core_pkg.sv
package accum_core_pkg;

    localparam int NIB_W   = 4;
    localparam int INSTR_W = 8;

    typedef enum logic [3:0] {
        OP_LOAD_A      = 4'h0,
        OP_LOAD_B      = 4'h1,
        OP_STORE_A     = 4'h2,
        OP_CONST_A     = 4'h3,
        OP_CONST_B     = 4'h4,
        OP_ADDR_A      = 4'h5,
        OP_IDX_LOAD_A  = 4'h6,
        OP_IDX_LOAD_B  = 4'h7,
        OP_IDX_STORE_A = 4'h8,
        OP_JUMP        = 4'h9,
        OP_JUMP_ZERO   = 4'hA,
        OP_JUMP_NEG    = 4'hB,
        OP_OPERATE     = 4'hD,
        OP_PREFIX      = 4'hE,
        OP_NPREFIX     = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        FN_JUMP_B = 2'd0,
        FN_ADD    = 2'd1,
        FN_SUB    = 2'd2,
        FN_CALL   = 2'd3
    } opfn_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXEC,
        ST_LOAD,
        ST_TRAP,
        ST_HALT
    } state_e;

    typedef struct packed {
        opcode_e            op;
        logic [NIB_W-1:0]   nib;
    } instr_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic load_b;
        logic trap;
        logic illegal;
        logic a_we;
        logic b_we;
    } ctrl_t;

endpackage

// File: rtl/accum_operand.sv
module accum_operand
    import accum_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  instr_t            instr,
    output logic [DATA_W-1:0] operand
);

    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] merged;

    assign merged  = opnd_q | {{(DATA_W-NIB_W){1'b0}}, instr.nib};
    assign operand = merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
        end else if (step) begin
            if (instr.op == OP_PREFIX) begin
                opnd_q <= merged << NIB_W;
            end else if (instr.op == OP_NPREFIX) begin
                opnd_q <= (~merged) << NIB_W;
            end else begin
                opnd_q <= '0;
            end
        end
    end

endmodule

// File: rtl/accum_exec.sv
module accum_exec
    import accum_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  instr_t            instr,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] bval,
    input  logic [DATA_W-1:0] pc_inc,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] pc_val,
    output logic [DATA_W-1:0] adr
);

    logic [DATA_W-1:0] rel_tgt;
    logic [DATA_W-1:0] idx_adr;

    assign rel_tgt = pc_inc + operand;
    assign idx_adr = bval + operand;

    always_comb begin
        ctrl   = '0;
        a_val  = acc;
        b_val  = bval;
        pc_val = pc_inc;
        adr    = '0;
        case (instr.op)
            OP_LOAD_A:      begin ctrl.rd = 1'b1; adr = operand; end
            OP_LOAD_B:      begin ctrl.rd = 1'b1; ctrl.load_b = 1'b1; adr = operand; end
            OP_STORE_A:     begin ctrl.wr = 1'b1; adr = operand; end
            OP_CONST_A:     begin ctrl.a_we = 1'b1; a_val = operand; end
            OP_CONST_B:     begin ctrl.b_we = 1'b1; b_val = operand; end
            OP_ADDR_A:      begin ctrl.a_we = 1'b1; a_val = rel_tgt; end
            OP_IDX_LOAD_A:  begin ctrl.rd = 1'b1; adr = idx_adr; end
            OP_IDX_LOAD_B:  begin ctrl.rd = 1'b1; ctrl.load_b = 1'b1; adr = idx_adr; end
            OP_IDX_STORE_A: begin ctrl.wr = 1'b1; adr = idx_adr; end
            OP_JUMP:        pc_val = rel_tgt;
            OP_JUMP_ZERO:   if (acc == '0) pc_val = rel_tgt;
            OP_JUMP_NEG:    if (acc[DATA_W-1]) pc_val = rel_tgt;
            OP_OPERATE: begin
                if (|operand[DATA_W-1:2]) begin
                    ctrl.illegal = 1'b1;
                end else begin
                    case (opfn_e'(operand[1:0]))
                        FN_JUMP_B: pc_val = bval;
                        FN_ADD:    begin ctrl.a_we = 1'b1; a_val = acc + bval; end
                        FN_SUB:    begin ctrl.a_we = 1'b1; a_val = acc - bval; end
                        default:   ctrl.trap = 1'b1;
                    endcase
                end
            end
            OP_PREFIX, OP_NPREFIX: ;
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/accum_core.sv
module accum_core
    import accum_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              trap_o,
    output logic [DATA_W-1:0] trap_a_o,
    output logic [DATA_W-1:0] trap_b_o,
    input  logic              trap_ack_i,
    output logic              halt_o
);

    localparam int LANES = DATA_W / INSTR_W;
    localparam int SEL_W = $clog2(LANES);

    state_e            state_q;
    logic [DATA_W-1:0] pc_q, a_q, b_q;
    logic              load_b_q;

    logic [INSTR_W-1:0] lane_w [LANES];
    instr_t             instr;
    logic [DATA_W-1:0]  operand, pc_inc, fetch_adr;
    ctrl_t              ctrl;
    logic [DATA_W-1:0]  x_a, x_b, x_pc, x_adr;
    logic               in_exec;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_w[g] = mem_rdata_i[g*INSTR_W +: INSTR_W];
    end

    assign instr     = instr_t'(lane_w[pc_q[SEL_W-1:0]]);
    assign pc_inc    = pc_q + {{(DATA_W-1){1'b0}}, 1'b1};
    assign fetch_adr = {{SEL_W{1'b0}}, pc_q[DATA_W-1:SEL_W]};
    assign in_exec   = (state_q == ST_EXEC);

    accum_operand #(.DATA_W(DATA_W)) opnd_i (
        .clk     (clk),
        .rst     (rst),
        .step    (in_exec),
        .instr   (instr),
        .operand (operand)
    );

    accum_exec #(.DATA_W(DATA_W)) exec_i (
        .instr   (instr),
        .operand (operand),
        .acc     (a_q),
        .bval    (b_q),
        .pc_inc  (pc_inc),
        .ctrl    (ctrl),
        .a_val   (x_a),
        .b_val   (x_b),
        .pc_val  (x_pc),
        .adr     (x_adr)
    );

    always_comb begin
        mem_rd_o    = (state_q == ST_FETCH) || (in_exec && ctrl.rd);
        mem_wr_o    = in_exec && ctrl.wr;
        mem_wdata_o = mem_wr_o ? a_q : '0;
        if (state_q == ST_FETCH) begin
            mem_addr_o = fetch_adr;
        end else if (in_exec && (ctrl.rd || ctrl.wr)) begin
            mem_addr_o = x_adr;
        end else begin
            mem_addr_o = '0;
        end
        trap_o   = (state_q == ST_TRAP);
        trap_a_o = trap_o ? a_q : '0;
        trap_b_o = trap_o ? b_q : '0;
        halt_o   = (state_q == ST_HALT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_FETCH;
            pc_q     <= '0;
            a_q      <= '0;
            b_q      <= '0;
            load_b_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH: state_q <= ST_EXEC;
                ST_EXEC: begin
                    if (ctrl.illegal) begin
                        state_q <= ST_HALT;
                    end else begin
                        pc_q <= x_pc;
                        if (ctrl.a_we) a_q <= x_a;
                        if (ctrl.b_we) b_q <= x_b;
                        load_b_q <= ctrl.load_b;
                        if (ctrl.trap)    state_q <= ST_TRAP;
                        else if (ctrl.rd) state_q <= ST_LOAD;
                        else              state_q <= ST_FETCH;
                    end
                end
                ST_LOAD: begin
                    if (load_b_q) b_q <= mem_rdata_i;
                    else          a_q <= mem_rdata_i;
                    state_q <= ST_FETCH;
                end
                ST_TRAP: if (trap_ack_i) state_q <= ST_FETCH;
                default: state_q <= ST_HALT;
            endcase
        end
    end

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic              trap_o,
    input logic [DATA_W-1:0] trap_a_o,
    input logic [DATA_W-1:0] trap_b_o,
    input logic              trap_ack_i,
    input logic              halt_o
);

    assert_rw_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    assert_store_then_fetch_R11: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |=> (mem_rd_o && !mem_wr_o));

    assert_trap_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (trap_o && !trap_ack_i) |=> (trap_o && $stable(trap_a_o) && $stable(trap_b_o)));

    assert_trap_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (!mem_rd_o && !mem_wr_o));

    assert_trap_release_R8: assert property (@(posedge clk) disable iff (rst)
        (trap_o && trap_ack_i) |=> (!trap_o && mem_rd_o));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> (halt_o && !mem_rd_o && !mem_wr_o && !trap_o));

endmodule

bind accum_core accum_core_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/accum_core_tb_top.sv
`timescale 1ns/1ps
module accum_core_tb_top;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata = '0, trap_a, trap_b;
    logic          mem_rd, mem_wr, trap, halt;
    logic          trap_ack = 1'b0;

    always #2.5 clk = ~clk;

    accum_core #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .trap_o(trap), .trap_a_o(trap_a), .trap_b_o(trap_b),
        .trap_ack_i(trap_ack), .halt_o(halt)
    );

    typedef struct {
        int          kind;   // 0 idle, 1 read, 2 write, 3 trap, 4 halted
        logic [31:0] ad;
        logic [31:0] d0;
        logic [31:0] d1;
        string       tag;
    } rec_t;

    logic [31:0] bmem [0:255];
    logic [31:0] rmem [0:255];
    rec_t        exp_q [$];
    int          checks = 0;
    int          fails  = 0;
    int          loc    = 0;
    bit          done   = 0;

    function automatic void push(int k, logic [31:0] ad, logic [31:0] d0, logic [31:0] d1, string t);
        rec_t r;
        r.kind = k; r.ad = ad; r.d0 = d0; r.d1 = d1; r.tag = t;
        exp_q.push_back(r);
    endfunction

    function automatic void clear_mem();
        for (int i = 0; i < 256; i++) begin
            bmem[i] = '0;
            rmem[i] = '0;
        end
        loc = 0;
    endfunction

    function automatic void emit(logic [7:0] v);
        bmem[loc >> 2][8*(loc % 4) +: 8] = v;
        rmem[loc >> 2][8*(loc % 4) +: 8] = v;
        loc++;
    endfunction

    function automatic void set_word(int idx, logic [31:0] v);
        bmem[idx] = v;
        rmem[idx] = v;
    endfunction

    // Behavioural reference: one instruction at a time, expanded into per-cycle port records
    task automatic build_expect();
        logic [31:0] pc = 0, a = 0, b = 0, o = 0, w, opd, npc, nxo, t;
        logic [7:0]  ib;
        bit          stop = 0;
        exp_q.delete();
        for (int s = 0; s < 600 && !stop; s++) begin
            push(1, pc >> 2, 0, 0, "R1");
            w   = rmem[(pc >> 2) & 32'd255];
            ib  = 8'(w >> (8 * pc[1:0]));
            opd = o | {28'd0, ib[3:0]};
            npc = pc + 1;
            nxo = 0;
            pc  = npc;
            case (ib[7:4])
                4'h0: begin push(1, opd, 0, 0, "R4"); push(0, 0, 0, 0, "R11"); a = rmem[opd[7:0]]; end
                4'h1: begin push(1, opd, 0, 0, "R4"); push(0, 0, 0, 0, "R11"); b = rmem[opd[7:0]]; end
                4'h2: begin push(2, opd, a, 0, "R4"); rmem[opd[7:0]] = a; end
                4'h3: begin a = opd; push(0, 0, 0, 0, "R3"); end
                4'h4: begin b = opd; push(0, 0, 0, 0, "R3"); end
                4'h5: begin a = npc + opd; push(0, 0, 0, 0, "R3"); end
                4'h6: begin t = b + opd; push(1, t, 0, 0, "R5"); push(0, 0, 0, 0, "R11"); a = rmem[t[7:0]]; end
                4'h7: begin t = b + opd; push(1, t, 0, 0, "R5"); push(0, 0, 0, 0, "R11"); b = rmem[t[7:0]]; end
                4'h8: begin t = b + opd; push(2, t, a, 0, "R5"); rmem[t[7:0]] = a; end
                4'h9: begin pc = npc + opd; push(0, 0, 0, 0, "R6"); end
                4'hA: begin if (a == 0) pc = npc + opd; push(0, 0, 0, 0, "R6"); end
                4'hB: begin if (a[31]) pc = npc + opd; push(0, 0, 0, 0, "R6"); end
                4'hD: begin
                    if (opd == 0)      begin pc = b; push(0, 0, 0, 0, "R7"); end
                    else if (opd == 1) begin a = a + b; push(0, 0, 0, 0, "R7"); end
                    else if (opd == 2) begin a = a - b; push(0, 0, 0, 0, "R7"); end
                    else if (opd == 3) begin
                        push(0, 0, 0, 0, "R8");
                        for (int k = 0; k < 3; k++) push(3, 0, a, b, "R8");
                    end else stop = 1;
                end
                4'hE: begin nxo = opd << 4; push(0, 0, 0, 0, "R2"); end
                4'hF: begin nxo = (~opd) << 4; push(0, 0, 0, 0, "R2"); end
                default: stop = 1;
            endcase
            o = nxo;
            if (stop) begin
                push(0, 0, 0, 0, "R9");
                for (int k = 0; k < 4; k++) push(4, 0, 0, 0, "R9");
            end
        end
    endtask

    task automatic compare_rec();
        rec_t r;
        bit ok, e_rd, e_wr, e_tr, e_h;
        r    = exp_q.pop_front();
        e_rd = (r.kind == 1);
        e_wr = (r.kind == 2);
        e_tr = (r.kind == 3);
        e_h  = (r.kind == 4);
        ok = (mem_rd == e_rd) && (mem_wr == e_wr) && (trap == e_tr) && (halt == e_h);
        if (e_rd || e_wr) ok = ok && (mem_addr == r.ad);
        if (e_wr) ok = ok && (mem_wdata == r.d0);
        if (e_tr) ok = ok && (trap_a == r.d0) && (trap_b == r.d1);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual rd=%0b wr=%0b trap=%0b halt=%0b addr=%h wdata=%h a=%h b=%h expected kind=%0d addr=%h d0=%h d1=%h",
                     r.tag, mem_rd, mem_wr, trap, halt, mem_addr, mem_wdata, trap_a, trap_b,
                     r.kind, r.ad, r.d0, r.d1);
        end
    endtask

    task automatic run_prog();
        int          trap_run = 0;
        bit          rd_now;
        logic [31:0] nxt;
        build_expect();
        rst = 1'b1;
        trap_ack = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (!(mem_rd && !mem_wr && !trap && !halt && mem_addr == 0)) begin
            fails++;
            $display("FAIL R10: actual rd=%0b wr=%0b trap=%0b halt=%0b addr=%h expected rd=1 wr=0 trap=0 halt=0 addr=0",
                     mem_rd, mem_wr, trap, halt, mem_addr);
        end
        rst = 1'b0;
        while (exp_q.size() > 0 && !done) begin
            compare_rec();
            rd_now = mem_rd;
            nxt = bmem[mem_addr[7:0]];
            if (mem_wr) bmem[mem_addr[7:0]] = mem_wdata;
            if (trap) begin
                trap_run++;
                trap_ack = (trap_run == 3);
            end else begin
                trap_run = 0;
                trap_ack = 1'b0;
            end
            @(posedge clk);
            if (rd_now) mem_rdata <= nxt;
            @(negedge clk);
        end
    endtask

    initial begin
        // Program 1: constants, prefixes, arithmetic, PC-relative, call, undefined opcode
        clear_mem();
        emit(8'h35); emit(8'hE2); emit(8'h20);              // R3 A=5, R4 store @0x20
        emit(8'hE1); emit(8'hE2); emit(8'h33);              // R2 A=0x123
        emit(8'hE2); emit(8'h21);
        emit(8'hF0); emit(8'h31);                           // R2 negative prefix A=-15
        emit(8'hE2); emit(8'h22);
        emit(8'h47); emit(8'hD1); emit(8'hE2); emit(8'h23); // R7 add
        emit(8'hD2); emit(8'hE2); emit(8'h24);              // R7 sub
        emit(8'h52); emit(8'hE2); emit(8'h25);              // R3 PC-relative
        emit(8'hD3);                                        // R8 call
        emit(8'hE2); emit(8'h26);                           // resumes after call
        emit(8'hC0);                                        // R9 undefined opcode
        run_prog();

        // Program 2: direct and indexed loads, branches, loop, jump to B, bad function
        clear_mem();
        set_word(8'h2F, 32'h0000_0055);
        set_word(8'h30, 32'h1111_1111);
        set_word(8'h31, 32'h8000_0000);
        set_word(8'h32, 32'h0000_ABCD);
        emit(8'hE3); emit(8'h00);                           // R4 A=mem[0x30]
        emit(8'hE3); emit(8'h11);                           // R4 B=mem[0x31]
        emit(8'hD3);                                        // R8
        emit(8'hE3); emit(8'h40);                           // B=0x30
        emit(8'h62); emit(8'h88);                           // R5 indexed load/store
        emit(8'hF0); emit(8'h6F);                           // R5 negative index
        emit(8'h71); emit(8'hD1);                           // R5 indexed B, A negative
        emit(8'hB2); emit(8'hC0); emit(8'hC0);              // R6 taken on negative
        emit(8'hA1); emit(8'h35);                           // R6 zero not taken
        emit(8'h30); emit(8'hA2); emit(8'hC0); emit(8'hC0); // R6 zero taken
        emit(8'hB1); emit(8'h30);                           // R6 negative not taken
        emit(8'h33);                                        // loop counter
        emit(8'h41); emit(8'hD2); emit(8'hA2); emit(8'hF0); emit(8'h9B); // R6 backward loop
        emit(8'hD3);
        emit(8'hE6); emit(8'h40); emit(8'hD0); emit(8'hC0); // R7 jump to B=0x60
        loc = 32'h60;
        emit(8'hE1); emit(8'hD0);                           // R9 function 16
        run_prog();

        // Program 3: byte lanes and forward jump
        clear_mem();
        emit(8'h97);                                        // R6 skip seven bytes
        for (int i = 0; i < 7; i++) emit(8'hC0);
        emit(8'h51); emit(8'hE2); emit(8'h20);              // R1 lane 0 of word 2
        emit(8'h45); emit(8'hD3);
        emit(8'hD7);                                        // R9 function 7
        run_prog();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual run still active expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule